// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

This block joins two 8-bit buses, called A and B, and can move data between them in either direction. Each direction has an output enable and a source select. With the select low, the direction passes the live value of the opposite bus. With the select high, it drives a value that a storage register captured earlier. Each bus pin is split into an input, an output and an output enable, so the block needs no tri-state cells. The surrounding pad logic merges these three signals into a real bus.

Each bus has its own capture strobe. The strobes are ordinary signals that the system clock samples. When the block sees a strobe rise, it loads that bus's register with the resolved bus value. The resolved value is what the block itself drives when its output is enabled, and the external input otherwise. Capture does not depend on any enable or select. Because of this, a live pass-through combined with two simultaneous strobes copies one bus into both registers.

Top module: `xcvr_regbus`

## Requirements
- R1: `b_oe` equals `en_ab`, so the A-to-B enable is active high. `a_oe` equals the inverse of `en_ba_n`, so the B-to-A enable is active low.
- R2: `b_out` equals `a_in` while `sel_ab` is 0 (live) and equals the stored A register while `sel_ab` is 1 (stored). A change of `sel_ab` takes effect combinationally and shows no third value.
- R3: `a_out` equals `b_in` while `sel_ba` is 0 and equals the stored B register while `sel_ba` is 1. The switch is also combinational.
- R4: Suppose a rising edge of the system clock, edge t, first samples `stb_a` high after sampling it low. Then the A register takes the resolved A bus value present at edge t. The new value appears on the outputs after edge t+1. The enables and selects have no effect on this capture.
- R5: The same rule as R4 applies to `stb_b`, the B register and the resolved B bus.
- R6: The resolved A bus is `a_out` when `a_oe` is 1 and `a_in` otherwise. The resolved B bus is `b_out` when `b_oe` is 1 and `b_in` otherwise.
- R7: Only a low-to-high change of a strobe causes a capture. A strobe held high captures nothing more, even when its bus changes.
- R8: With `en_ab` at 0 and `en_ba_n` at 1, both `a_oe` and `b_oe` are 0. Captures still work in this state.
- R9: With both directions enabled and both selects at 1, `b_out` shows the stored A value and `a_out` shows the stored B value at the same time.
- R10: With `en_ab` at 1, `en_ba_n` at 1 and `sel_ab` at 0, strobing both registers in the same cycle loads `a_in` into both. With the roles mirrored, `b_in` is loaded into both.
- R11: A synchronous active-high `rst` clears both registers and the strobe history to 0.
- R12: When both strobes rise together, each capture sees the register contents from before that capture. A direction that drives its stored value therefore passes the old stored value to the other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Value seen on the A bus pins |
| a_out | output | 8 | Value the block drives onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | 8 | Value seen on the B bus pins |
| b_out | output | 8 | Value the block drives onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus |
| en_ab | input | 1 | A-to-B direction enable, active high |
| en_ba_n | input | 1 | B-to-A direction enable, active low |
| sel_ab | input | 1 | Source for B output: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A output: 0 live B, 1 stored B |
| stb_a | input | 1 | Capture strobe for the A register |
| stb_b | input | 1 | Capture strobe for the B register |

## Verification
The assertions assume that the strobes and every other input change only between clock edges and stay at a valid 0 or 1 level when an edge samples them. They also assume the bus values do not change in the cycle when a strobe is first seen high. The bench drives all inputs on the falling edge. It holds each bus steady from the moment a strobe is raised until the capture is visible. It then reads both registers back through the stored-output path, so the check needs no view of internal state.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    typedef struct packed {
        logic seen;
        logic fire;
    } strobe_st_t;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [W-1:0] bus_res,
    output logic [W-1:0] held
);
    import xcvr_pkg::*;

    typedef struct packed {
        strobe_st_t   edge_s;
        logic [W-1:0] snap;
        logic [W-1:0] held;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.edge_s.seen = stb;
        st_d.edge_s.fire = stb & ~st_q.edge_s.seen;
        st_d.snap        = bus_res;
        if (st_q.edge_s.fire) begin
            st_d.held = st_q.snap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.held;

    // R4 / R5: a detected edge loads the snapshot taken on that edge
    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.edge_s.fire |=> (held == $past(st_q.snap)));

    // R7: without a detected edge the register keeps its contents
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !st_q.edge_s.fire |=> $stable(held));

    // R7: a fire lasts exactly one cycle per rise
    assert_single_fire_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.edge_s.fire |=> !st_q.edge_s.fire);

    assert_rise_fires_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.edge_s.seen) |-> st_q.edge_s.fire);

    // R11: reset leaves the register cleared
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (held == '0));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
    parameter int unsigned W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] drive
);
    import xcvr_pkg::*;

    src_e src;
    assign src = src_e'(sel);

    for (genvar i = 0; i < W; i++) begin : g_lane
        always_comb begin
            unique case (src)
                SRC_STORED: drive[i] = stored[i];
                default:    drive[i] = live[i];
            endcase
        end
    end

endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         stb_a,
    input  logic         stb_b
);
    logic [W-1:0] held_a, held_b;
    logic [W-1:0] res_a, res_b;

    // enable decode (R1)
    assign b_oe = en_ab;
    assign a_oe = ~en_ba_n;

    // live paths take the raw opposite input, never the resolved bus
    xcvr_path #(.W(W)) u_path_ab (
        .sel    (sel_ab),
        .live   (a_in),
        .stored (held_a),
        .drive  (b_out)
    );

    xcvr_path #(.W(W)) u_path_ba (
        .sel    (sel_ba),
        .live   (b_in),
        .stored (held_b),
        .drive  (a_out)
    );

    // bus resolution for capture (R6)
    assign res_a = a_oe ? a_out : a_in;
    assign res_b = b_oe ? b_out : b_in;

    xcvr_capture #(.W(W)) u_cap_a (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb_a),
        .bus_res (res_a),
        .held    (held_a)
    );

    xcvr_capture #(.W(W)) u_cap_b (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb_b),
        .bus_res (res_b),
        .held    (held_b)
    );

    assert_isolate_R8: assert property (@(posedge clk) disable iff (rst)
        (!en_ab && en_ba_n) |-> (!a_oe && !b_oe));

    assert_stored_b_R2: assert property (@(posedge clk) disable iff (rst)
        (b_oe && sel_ab) |-> (b_out == held_a));

    assert_live_a_R3: assert property (@(posedge clk) disable iff (rst)
        (a_oe && !sel_ba) |-> (a_out == b_in));

    assert_swap_R9: assert property (@(posedge clk) disable iff (rst)
        (a_oe && b_oe && sel_ab && sel_ba) |-> (a_out == held_b && b_out == held_a));

endmodule

// File: tb/xcvr_regbus_tb.sv
module xcvr_regbus_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic a_oe, b_oe, en_ab, en_ba_n, sel_ab, sel_ba, stb_a, stb_b;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    logic [W-1:0] exp_a, exp_b;
    logic [15:0]  lfsr = 16'hACE1;

    always #2 clk = ~clk;

    xcvr_regbus #(.W(W)) u_dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .en_ab(en_ab), .en_ba_n(en_ba_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba),
        .stb_a(stb_a), .stb_b(stb_b)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[W-1:0];
    endfunction

    // read both registers back through the stored output paths
    task automatic view(input string tag);
        @(negedge clk);
        en_ab = 1'b1; sel_ab = 1'b1; en_ba_n = 1'b0; sel_ba = 1'b1;
        stb_a = 1'b0; stb_b = 1'b0;
        #1;
        chk({tag, " regA"}, b_out, exp_a);
        chk({tag, " regB"}, a_out, exp_b);
    endtask

    task automatic step(input logic eab, input logic eban, input logic sab, input logic sba,
                        input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic pa, input logic pb, input string tag);
        logic [W-1:0] ra, rb, eb, ea;
        @(negedge clk);
        en_ab = eab; en_ba_n = eban; sel_ab = sab; sel_ba = sba;
        a_in = av; b_in = bv;
        #1;
        chk({tag, " R1 b_oe"}, {7'd0, b_oe}, {7'd0, eab});
        chk({tag, " R1 a_oe"}, {7'd0, a_oe}, {7'd0, ~eban});
        eb = sab ? exp_a : av;
        ea = sba ? exp_b : bv;
        chk({tag, " R2 b_out"}, b_out, eb);
        chk({tag, " R3 a_out"}, a_out, ea);
        // R6: resolved buses
        ra = !eban ? ea : av;
        rb = eab ? eb : bv;
        stb_a = pa; stb_b = pb;
        @(negedge clk);
        stb_a = 1'b0; stb_b = 1'b0;
        @(negedge clk);
        // R12: both new values come from pre-capture contents
        if (pa) exp_a = ra;
        if (pb) exp_b = rb;
        view({tag, " R4/R5/R6"});
    endtask

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0; en_ab = 1'b0; en_ba_n = 1'b1;
        sel_ab = 1'b0; sel_ba = 1'b0; stb_a = 1'b0; stb_b = 1'b0;
        exp_a = '0; exp_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        view("R11 reset");

        // live sweep over every data value (R2, R3)
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
            a_in = W'(v); b_in = ~W'(v);
            #1;
            chk("R2 live b_out", b_out, W'(v));
            chk("R3 live a_out", a_out, ~W'(v));
        end

        // R8: isolation with captures still active
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC3, 1'b1, 1'b1, "R8 isolate");
        chk("R8 captured A", exp_a, 8'h5A);
        chk("R8 captured B", exp_b, 8'hC3);

        // R2/R3: select switches in the same cycle
        @(negedge clk);
        en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
        a_in = 8'h11; b_in = 8'h22;
        #1;
        chk("R2 switch live", b_out, 8'h11);
        sel_ab = 1'b1; sel_ba = 1'b1;
        #1;
        chk("R2 switch stored", b_out, 8'h5A);
        chk("R3 switch stored", a_out, 8'hC3);
        // R9: swap stored values
        chk("R9 swap B side", b_out, 8'h5A);
        chk("R9 swap A side", a_out, 8'hC3);

        // R10: copy A into both, then B into both
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h99, 1'b1, 1'b1, "R10 A both");
        chk("R10 A both regA", exp_a, 8'h3C);
        chk("R10 A both regB", exp_b, 8'h3C);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 8'hE1, 1'b1, 1'b1, "R10 B both");
        chk("R10 B both regA", exp_a, 8'hE1);
        chk("R10 B both regB", exp_b, 8'hE1);

        // R12: stored swap with simultaneous strobes exchanges old values
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h0F, 1'b1, 1'b1, "R12 preload");
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1, "R12 exchange");
        chk("R12 regA old B", exp_a, 8'h0F);
        chk("R12 regB old A", exp_b, 8'hA5);

        // R7: strobe held high does not recapture
        @(negedge clk);
        en_ab = 1'b0; en_ba_n = 1'b1; a_in = 8'h42; stb_a = 1'b1;
        repeat (3) @(negedge clk);
        a_in = 8'hBD;
        repeat (3) @(negedge clk);
        exp_a = 8'h42;
        view("R7 held strobe");

        // sweep every control combination and strobe pattern (R4, R5, R6)
        for (int c = 0; c < 16; c++) begin
            for (int s = 1; s < 4; s++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [W-1:0] av, bv;
                    av = next_rand();
                    bv = next_rand();
                    step(c[0], c[1], c[2], c[3], av, bv, s[0], s[1], "R4 R5 sweep");
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule